// File: doc/BRIEF.md
# DMA Address Allow-List Filter

This block sits in front of a DMA engine and decides, for every request address, whether the access may proceed. It keeps a table of sixteen physical memory windows. A request passes only when its address falls inside at least one active window. The block never translates anything. A permitted request comes out with exactly the address it went in with, so the filter can be placed on any path where remapping is not wanted.

Software sets up the windows through a small word-addressed register port. Each window has a flags byte, a base page and a length in pages, and a page is 4 KiB. A window is active whenever its flags byte is nonzero, and the value 0xFF is the one used to grant access. The placement of the length field is fixed at build time by a parameter. In the packed form the length shares a word with the flags. In the split form the length has its own word and can reach 30 bits. Windows can be loaded at reset from parameters, which model entries that boot firmware left behind. These preset windows read back like any other window.

The verdict is registered. It appears on the cycle after the request strobe, as a pair of one-hot allow and deny lines next to the unchanged address.

Top module: `dma_region_gate`

## Requirements
- R1: After reset the response strobe, allow and deny are low, and every entry holds its preset flags, base and length, which read back through the register port.
- R2: Entry i (0 to 15) has its configuration word at byte offset 4*i and its base word at byte offset 0x40 + 4*i. The base word holds the start address shifted right by 12.
- R3: With the packed layout (SPLIT_LAYOUT = 0) the configuration word carries the flags in bits [31:24] and the length in 4 KiB pages in bits [23:0].
- R4: With the split layout (SPLIT_LAYOUT = 1) the configuration word carries only the flags in bits [7:0], and the length in pages sits in bits [29:0] of the word at offset 0x80 + 4*i.
- R5: A request at address A is allowed when some entry with nonzero flags satisfies base*4096 <= A < (base+length)*4096. The window edges are inclusive at the bottom and exclusive at the top.
- R6: An entry with zero flags never allows a request, even when A lies inside its window. A request that hits no active entry is denied.
- R7: The response strobe rises exactly one clock after each request strobe. While it is high exactly one of allow and deny is high. Without a request all three stay low.
- R8: The forwarded address equals the request address bit for bit.
- R9: A register write takes effect for requests presented on the following cycle. A request presented in the same cycle as the write is judged against the old table.
- R10: Reads at unused offsets return zero, and writes there change no entry. The unused offsets are those with nonzero bits [1:0], offsets 0xC0 and above, and 0x80 to 0xBF in the packed layout.
- R11: With several active entries, an address inside any one of them is allowed and an address between them is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dma_req_valid | input | 1 | Request strobe |
| dma_req_addr | input | ADDR_W | Request physical address |
| dma_resp_valid | output | 1 | Verdict strobe, one cycle after the request |
| dma_allow | output | 1 | Request permitted |
| dma_deny | output | 1 | Request blocked |
| dma_fwd_addr | output | ADDR_W | Request address passed through unchanged |

## Verification
The hardest case to reach from the ports is a register write and a request landing in the same clock, where the verdict must still reflect the old table. The bench first programs the base word of a spare entry. It then drives the flags write and a request inside that window on the same cycle, expects a deny, and repeats the request one cycle later to expect an allow. Both window edges are probed at the last byte inside and the first byte outside. Each layout gets its own instance, so that the 30-bit length field and the packed field positions are both exercised.

// File: rtl/dma_region_gate_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the DMA allow-list filter.
// Assumes a 32-bit register word and 4 KiB page granularity.
package dma_region_gate_pkg;
    localparam int FLAG_W        = 8;
    localparam int PAGE_SHIFT    = 12;
    localparam int PACKED_SIZE_W = 24;
    localparam int SPLIT_SIZE_W  = 30;
    localparam int CMP_W         = 33;

    // Register group selected by byte offset bits [7:6]
    typedef enum logic [1:0] {
        GRP_CFG  = 2'd0,
        GRP_BASE = 2'd1,
        GRP_SIZE = 2'd2,
        GRP_NONE = 2'd3
    } reg_grp_e;

    // One window: flags, base page, length in pages (widest form)
    typedef struct packed {
        logic [FLAG_W-1:0]       flags;
        logic [31:0]             base;
        logic [SPLIT_SIZE_W-1:0] size;
    } region_t;
endpackage

// File: rtl/region_regfile.sv
`timescale 1ns/1ps
// Holds the window table and serves the register port.
// Assumes at most 16 entries (4-bit index in offset bits [5:2]).
// The field layout is chosen by SPLIT_LAYOUT; reads are combinational.
module region_regfile
    import dma_region_gate_pkg::*;
#(
    parameter int NUM_ENTRIES  = 16,
    parameter bit SPLIT_LAYOUT = 1'b0,
    parameter int BASE_W       = 28,
    parameter logic [NUM_ENTRIES*8-1:0]  BOOT_FLAGS = '0,
    parameter logic [NUM_ENTRIES*32-1:0] BOOT_BASE  = '0,
    parameter logic [NUM_ENTRIES*32-1:0] BOOT_SIZE  = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output region_t     regions [NUM_ENTRIES]
);
    localparam int SIZE_W = SPLIT_LAYOUT ? SPLIT_SIZE_W : PACKED_SIZE_W;
    localparam logic [32:0] BASE_MASK_X = (33'h1 << BASE_W) - 33'h1;
    localparam logic [30:0] SIZE_MASK_X = (31'h1 << SIZE_W) - 31'h1;
    localparam logic [31:0] BASE_MASK   = BASE_MASK_X[31:0];
    localparam logic [SPLIT_SIZE_W-1:0] SIZE_MASK = SIZE_MASK_X[SPLIT_SIZE_W-1:0];

    reg_grp_e   grp;
    logic [3:0] idx;
    logic       in_range;
    logic       sel_ok;

    // Build one preset entry from the boot parameters
    function automatic region_t boot_entry(input int i);
        region_t r;
        r.flags = BOOT_FLAGS[i*8 +: 8];
        r.base  = BOOT_BASE[i*32 +: 32] & BASE_MASK;
        r.size  = BOOT_SIZE[i*32 +: SPLIT_SIZE_W] & SIZE_MASK;
        return r;
    endfunction

    generate
        if (NUM_ENTRIES >= 16) begin : g_full
            assign in_range = 1'b1;
        end else begin : g_part
            assign in_range = ({1'b0, idx} < 5'(NUM_ENTRIES));
        end
    endgenerate

    // Decode the byte offset into group, index and a legality flag
    always_comb begin
        grp    = reg_grp_e'(addr[7:6]);
        idx    = addr[5:2];
        sel_ok = (addr[1:0] == 2'b00) && in_range && (grp != GRP_NONE)
                 && !((grp == GRP_SIZE) && !SPLIT_LAYOUT);
    end

    // Table storage: preset on reset, updated by legal writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                regions[i] <= boot_entry(i);
            end
        end else if (wr_en && sel_ok) begin
            case (grp)
                GRP_CFG: begin
                    if (SPLIT_LAYOUT) begin
                        regions[idx].flags <= wdata[7:0];
                    end else begin
                        regions[idx].flags <= wdata[31:24];
                        regions[idx].size  <= {6'b0, wdata[23:0]};
                    end
                end
                GRP_BASE: regions[idx].base <= wdata & BASE_MASK;
                GRP_SIZE: regions[idx].size <= wdata[29:0] & SIZE_MASK;
                default: ;
            endcase
        end
    end

    // Read mux: zero for anything not mapped
    always_comb begin
        rdata = '0;
        if (sel_ok) begin
            case (grp)
                GRP_CFG:  rdata = SPLIT_LAYOUT ? {24'b0, regions[idx].flags}
                                               : {regions[idx].flags, regions[idx].size[23:0]};
                GRP_BASE: rdata = regions[idx].base;
                GRP_SIZE: rdata = {2'b0, regions[idx].size};
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/region_match.sv
`timescale 1ns/1ps
// Compares one request page against every window in parallel.
// Assumes page-granular windows; the top bound is exclusive.
module region_match
    import dma_region_gate_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int PAGE_W      = 28
) (
    input  region_t           regions [NUM_ENTRIES],
    input  logic [PAGE_W-1:0] page,
    output logic [NUM_ENTRIES-1:0] hit_vec
);
    logic [CMP_W-1:0] page_x;

    // Widen the request page for overflow-free comparison
    always_comb page_x = CMP_W'(page);

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
            logic [CMP_W-1:0] lo;
            logic [CMP_W-1:0] hi;
            // Per-entry window bounds and hit decision
            always_comb begin
                lo         = {1'b0, regions[g].base};
                hi         = lo + CMP_W'(regions[g].size);
                hit_vec[g] = (|regions[g].flags) && (page_x >= lo) && (page_x < hi);
            end
        end
    endgenerate
endmodule

// File: rtl/dma_region_gate.sv
`timescale 1ns/1ps
// DMA address allow-list filter top level.
// Checks each request against the window table and registers the
// verdict; the address is forwarded unmodified. Assumes ADDR_W <= 44.
module dma_region_gate
    import dma_region_gate_pkg::*;
#(
    parameter int ADDR_W       = 40,
    parameter int NUM_ENTRIES  = 16,
    parameter bit SPLIT_LAYOUT = 1'b0,
    parameter logic [NUM_ENTRIES*8-1:0]  BOOT_FLAGS = {8'hFF, {(NUM_ENTRIES-1){8'h00}}},
    parameter logic [NUM_ENTRIES*32-1:0] BOOT_BASE  = {32'h0000_0080, {(NUM_ENTRIES-1){32'h0}}},
    parameter logic [NUM_ENTRIES*32-1:0] BOOT_SIZE  = {32'h0000_0004, {(NUM_ENTRIES-1){32'h0}}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              dma_req_valid,
    input  logic [ADDR_W-1:0] dma_req_addr,
    output logic              dma_resp_valid,
    output logic              dma_allow,
    output logic              dma_deny,
    output logic [ADDR_W-1:0] dma_fwd_addr
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam int BASE_W = (PAGE_W > 32) ? 32 : PAGE_W;

    region_t                regions [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic                   hit_any;

    region_regfile #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .SPLIT_LAYOUT(SPLIT_LAYOUT),
        .BASE_W      (BASE_W),
        .BOOT_FLAGS  (BOOT_FLAGS),
        .BOOT_BASE   (BOOT_BASE),
        .BOOT_SIZE   (BOOT_SIZE)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .regions(regions)
    );

    region_match #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .PAGE_W     (PAGE_W)
    ) u_match (
        .regions(regions),
        .page   (dma_req_addr[ADDR_W-1:PAGE_SHIFT]),
        .hit_vec(hit_vec)
    );

    // Any active window containing the page grants access
    always_comb hit_any = |hit_vec;

    // Register the verdict and the pass-through address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_resp_valid <= 1'b0;
            dma_allow      <= 1'b0;
            dma_deny       <= 1'b0;
            dma_fwd_addr   <= '0;
        end else begin
            dma_resp_valid <= dma_req_valid;
            dma_allow      <= dma_req_valid && hit_any;
            dma_deny       <= dma_req_valid && !hit_any;
            dma_fwd_addr   <= dma_req_addr;
        end
    end
endmodule

// File: rtl/dma_region_gate_chk.sv
`timescale 1ns/1ps
// Property checker for the allow-list filter, bound into the top.
// Observes ports and the per-entry hit vector from the match logic.
module dma_region_gate_chk #(
    parameter int ADDR_W      = 40,
    parameter int NUM_ENTRIES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dma_req_valid,
    input logic [ADDR_W-1:0]      dma_req_addr,
    input logic                   dma_resp_valid,
    input logic                   dma_allow,
    input logic                   dma_deny,
    input logic [ADDR_W-1:0]      dma_fwd_addr,
    input logic [NUM_ENTRIES-1:0] hit_vec,
    input logic [7:0]             reg_addr,
    input logic [31:0]            reg_rdata
);
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |=> dma_resp_valid); // R7
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req_valid |=> !dma_resp_valid); // R7
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        dma_resp_valid |-> (dma_allow ^ dma_deny)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_resp_valid |-> !(dma_allow || dma_deny)); // R7
    AST_ADDR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_valid |=> (dma_fwd_addr == $past(dma_req_addr))); // R8
    AST_HIT_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_valid && (hit_vec != '0)) |=> dma_allow); // R5
    AST_MISS_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_valid && (hit_vec == '0)) |=> dma_deny); // R6
    AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr[7:6] == 2'b11) || (reg_addr[1:0] != 2'b00)) |-> (reg_rdata == '0)); // R10
endmodule

bind dma_region_gate dma_region_gate_chk #(
    .ADDR_W     (ADDR_W),
    .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dma_req_valid (dma_req_valid),
    .dma_req_addr  (dma_req_addr),
    .dma_resp_valid(dma_resp_valid),
    .dma_allow     (dma_allow),
    .dma_deny      (dma_deny),
    .dma_fwd_addr  (dma_fwd_addr),
    .hit_vec       (hit_vec),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata)
);

// File: tb/dma_region_gate_bench.sv
`timescale 1ns/1ps
// Directed bench: one packed-layout instance and one split-layout instance.
module dma_region_gate_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   errors = 0;

    logic        p_we = 0, s_we = 0;
    logic [7:0]  p_addr = 0, s_addr = 0;
    logic [31:0] p_wd = 0, s_wd = 0, p_rd, s_rd;
    logic        p_rv = 0, s_rv = 0;
    logic [39:0] p_ra = 0, s_ra = 0;
    logic        p_resp, s_resp, p_allow, s_allow, p_deny, s_deny;
    logic [39:0] p_fwd, s_fwd;

    always #5 clk = ~clk;

    dma_region_gate u_dma_region_gate (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(p_we), .reg_addr(p_addr), .reg_wdata(p_wd), .reg_rdata(p_rd),
        .dma_req_valid(p_rv), .dma_req_addr(p_ra),
        .dma_resp_valid(p_resp), .dma_allow(p_allow), .dma_deny(p_deny),
        .dma_fwd_addr(p_fwd)
    );

    dma_region_gate #(.SPLIT_LAYOUT(1'b1)) u_split (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(s_we), .reg_addr(s_addr), .reg_wdata(s_wd), .reg_rdata(s_rd),
        .dma_req_valid(s_rv), .dma_req_addr(s_ra),
        .dma_resp_valid(s_resp), .dma_allow(s_allow), .dma_deny(s_deny),
        .dma_fwd_addr(s_fwd)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input bit sp, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        if (sp) begin s_we = 1; s_addr = a; s_wd = d; end
        else    begin p_we = 1; p_addr = a; p_wd = d; end
        @(negedge clk);
        p_we = 0; s_we = 0;
    endtask

    task automatic reg_expect(input bit sp, input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        if (sp) s_addr = a; else p_addr = a;
        #1;
        check(tag, sp ? s_rd : p_rd, exp);
    endtask

    task automatic req_expect(input bit sp, input logic [39:0] a, input bit ok, input string tag);
        @(negedge clk);
        if (sp) begin s_rv = 1; s_ra = a; end else begin p_rv = 1; p_ra = a; end
        @(negedge clk);
        p_rv = 0; s_rv = 0;
        check({tag, " R7 valid"}, sp ? s_resp : p_resp, 1);
        check({tag, " allow"}, sp ? s_allow : p_allow, ok);
        check({tag, " deny"}, sp ? s_deny : p_deny, !ok);
        check({tag, " R8 fwd"}, sp ? s_fwd : p_fwd, a);
    endtask

    // R1, R2: reset state and preset entry read-back
    task automatic t_reset();
        check("R1 resp_valid after reset", p_resp, 0);
        check("R1 allow after reset", p_allow, 0);
        check("R1 deny after reset", p_deny, 0);
        reg_expect(0, 8'h3C, 32'hFF00_0004, "R1 R2 preset cfg entry15");
        reg_expect(0, 8'h7C, 32'h0000_0080, "R1 R2 preset base entry15");
        reg_expect(0, 8'h00, 32'h0, "R1 entry0 cfg empty");
        reg_expect(1, 8'h3C, 32'h0000_00FF, "R1 R4 split preset flags");
        reg_expect(1, 8'hBC, 32'h0000_0004, "R1 R4 split preset size");
    endtask

    // R5: window edges of the preset entry
    task automatic t_boot_window();
        req_expect(0, 40'h80000, 1, "R5 bottom edge");
        req_expect(0, 40'h83FFF, 1, "R5 last byte");
        req_expect(0, 40'h84000, 0, "R5 first byte above");
        req_expect(0, 40'h7FFFF, 0, "R5 byte below");
    endtask

    // R3, R2: packed programming and read-back
    task automatic t_packed();
        reg_write(0, 8'h4C, 32'h100);
        reg_write(0, 8'h0C, 32'hFF00_0002);
        reg_expect(0, 8'h0C, 32'hFF00_0002, "R3 cfg read-back");
        reg_expect(0, 8'h4C, 32'h100, "R2 base read-back");
        req_expect(0, 40'h101ABC, 1, "R3 inside");
        req_expect(0, 40'h102000, 0, "R3 above");
    endtask

    // R6: zero flags disable an entry
    task automatic t_flags_zero();
        reg_write(0, 8'h0C, 32'h0000_0002);
        req_expect(0, 40'h101000, 0, "R6 zero flags");
        reg_write(0, 8'h4C, 32'h0);
        reg_expect(0, 8'h0C, 32'h0000_0002, "R6 cfg after clear");
        req_expect(0, 40'h0, 0, "R6 cleared entry");
    endtask

    // R9: same-cycle write uses old table, next cycle the new one
    task automatic t_same_cycle();
        reg_write(0, 8'h54, 32'h300);
        @(negedge clk);
        p_we = 1; p_addr = 8'h14; p_wd = 32'hFF00_0001;
        p_rv = 1; p_ra = 40'h300800;
        @(negedge clk);
        p_we = 0; p_rv = 0;
        check("R9 same-cycle allow", p_allow, 0);
        check("R9 same-cycle deny", p_deny, 1);
        req_expect(0, 40'h300800, 1, "R9 next cycle");
    endtask

    // R7: no strobe, no response
    task automatic t_idle();
        repeat (3) @(negedge clk);
        check("R7 idle resp_valid", p_resp, 0);
        check("R7 idle allow", p_allow, 0);
        check("R7 idle deny", p_deny, 0);
    endtask

    // R10: unused offsets read zero and ignore writes
    task automatic t_unused();
        reg_expect(0, 8'h80, 32'h0, "R10 packed 0x80 read");
        reg_write(0, 8'h80, 32'hFFFF_FFFF);
        reg_write(0, 8'hC0, 32'hFFFF_FFFF);
        reg_write(0, 8'h3D, 32'hFFFF_FFFF);
        reg_expect(0, 8'h80, 32'h0, "R10 packed 0x80 after write");
        reg_expect(0, 8'hC0, 32'h0, "R10 0xC0 read");
        reg_expect(0, 8'h3D, 32'h0, "R10 misaligned read");
        reg_expect(0, 8'h3C, 32'hFF00_0004, "R10 entry15 unchanged");
        reg_expect(0, 8'h00, 32'h0, "R10 entry0 unchanged");
        req_expect(0, 40'h84000, 0, "R10 window unchanged");
    endtask

    // R4: split layout with a length wider than 24 bits
    task automatic t_split();
        reg_write(1, 8'h40, 32'h200);
        reg_write(1, 8'h80, 32'h0100_0000);
        reg_write(1, 8'h00, 32'h0000_00FF);
        reg_expect(1, 8'h00, 32'h0000_00FF, "R4 split cfg read-back");
        reg_expect(1, 8'h80, 32'h0100_0000, "R4 split size read-back");
        req_expect(1, 40'h10_001F_F000, 1, "R4 wide window inside");
        req_expect(1, 40'h10_0020_0000, 0, "R4 wide window above");
        reg_write(1, 8'h00, 32'hFF00_0000);
        reg_expect(1, 8'h80, 32'h0100_0000, "R4 size kept by cfg write");
        req_expect(1, 40'h20_0000, 0, "R4 high byte not flags");
    endtask

    // R11: multiple disjoint windows
    task automatic t_multi();
        reg_write(0, 8'h5C, 32'h1000);
        reg_write(0, 8'h1C, 32'hFF00_0001);
        reg_write(0, 8'h64, 32'h2000);
        reg_write(0, 8'h24, 32'hFF00_0002);
        req_expect(0, 40'h1000FFF, 1, "R11 first window");
        req_expect(0, 40'h2001FFF, 1, "R11 second window");
        req_expect(0, 40'h1800000, 0, "R11 gap");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R7: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boot_window();
        t_packed();
        t_flags_zero();
        t_same_cycle();
        t_idle();
        t_unused();
        t_split();
        t_multi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule